// File: doc/BRIEF.md
# Next-PC Computation Unit

This block holds the program counter of a single-cycle processor. Every clock it loads a new value. In the normal case that value is the current PC advanced by one 4-byte instruction word. When the current instruction is a compare-and-branch whose two source operands match, the new value is instead a relative target. That target is the advanced PC plus the instruction's 16-bit offset, sign extended and scaled by four.

The decode stage supplies two flags. One says that the instruction is the equality branch; the other says the register comparison found the operands equal. The block qualifies the branch with both flags. A separate incrementer forms the sequential address and a second adder forms the target from it. A two-way selector picks one of them. The registered PC drives the instruction memory address port directly.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc` becomes 0 after that edge; reset is synchronous.
- R2: With `br_op` low and `src_eq` low, `pc` advances by exactly 4 at each edge.
- R3: With `br_op` high and `src_eq` high, the next `pc` is the old `pc` + 4 + (the 16-bit `imm`, read as two's complement and sign extended to 32 bits, multiplied by 4).
- R4: With `br_op` high and `src_eq` low, the branch is not taken and `pc` advances by 4.
- R5: With `src_eq` high and `br_op` low, the branch is not taken and `pc` advances by 4.
- R6: A negative `imm` (bit 15 set) with a taken branch moves `pc` backwards. The result wraps modulo 2^32; for example, `imm` = 16'hFFFE taken at `pc` = 0 gives 32'hFFFFFFFC.
- R7: Sequential advance wraps modulo 2^32, so `pc` = 32'hFFFFFFFC is followed by 0.
- R8: After reset, bits [1:0] of `pc` stay 0 in every cycle.
- R9: When the branch is not taken, the value of `imm` has no effect on `pc`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| br_op | input | 1 | Current instruction is the equality branch |
| src_eq | input | 1 | The two source operands compared equal |
| imm | input | 16 | Signed word offset taken from the instruction |
| pc | output | 32 | Current program counter (instruction address) |

## Verification
The assertions assume that `br_op`, `src_eq` and `imm` are settled before each rising edge and are never unknown while reset is low. The bench changes them only on the falling edge. The checker relates each PC value to the value one cycle earlier. For that reason, every property ignores the first edge after reset, where no earlier PC exists. The stimulus reaches the top of the address space through a backward branch from 0, which exercises the negative-offset path and the wrap at the top of the address space.

// File: rtl/npc_pkg.sv
package npc_pkg;

    // Which of the two candidate addresses is loaded into the PC.
    typedef enum logic {
        NPC_PICK_SEQ = 1'b0,
        NPC_PICK_TGT = 1'b1
    } npc_pick_e;

endpackage

// File: rtl/npc_seq_add.sv
module npc_seq_add #(
    parameter int PC_W = 32,
    parameter int STEP = 4
) (
    input  logic [PC_W-1:0] cur_pc,
    output logic [PC_W-1:0] seq_pc
);
    localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

    // Sequential address; the carry out is dropped so the count wraps.
    always_comb begin
        seq_pc = cur_pc + STEP_V;
    end
endmodule

// File: rtl/npc_tgt_add.sv
module npc_tgt_add #(
    parameter int PC_W  = 32,
    parameter int IMM_W = 16,
    parameter int SHIFT = 2
) (
    input  logic [PC_W-1:0]  seq_pc,
    input  logic [IMM_W-1:0] imm,
    output logic [PC_W-1:0]  tgt_pc
);
    logic [PC_W-1:0] ext_w;
    logic [PC_W-1:0] off_w;

    // Sign extension, or truncation if the PC is narrower than the offset.
    generate
        if (PC_W > IMM_W) begin : g_ext
            assign ext_w = {{(PC_W-IMM_W){imm[IMM_W-1]}}, imm};
        end else begin : g_trunc
            assign ext_w = imm[PC_W-1:0];
        end
    endgenerate

    always_comb begin
        off_w  = ext_w << SHIFT;
        tgt_pc = seq_pc + off_w;
    end
endmodule

// File: rtl/npc_pick.sv
module npc_pick
    import npc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            br_op,
    input  logic            src_eq,
    input  logic [PC_W-1:0] seq_pc,
    input  logic [PC_W-1:0] tgt_pc,
    output npc_pick_e       pick,
    output logic [PC_W-1:0] nxt_pc
);
    // The branch is taken only when both qualifiers hold.
    always_comb begin
        pick = (br_op && src_eq) ? NPC_PICK_TGT : NPC_PICK_SEQ;
        unique case (pick)
            NPC_PICK_TGT: nxt_pc = tgt_pc;
            default:      nxt_pc = seq_pc;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int IMM_W    = 16,
    parameter int STEP     = 4,
    parameter int SHIFT    = 2,
    parameter int RESET_PC = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             br_op,
    input  logic             src_eq,
    input  logic [IMM_W-1:0] imm,
    output logic [PC_W-1:0]  pc
);
    localparam logic [PC_W-1:0] RST_V = PC_W'(RESET_PC);

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } npc_state_t;

    npc_state_t state_d;
    npc_state_t state_q;

    logic [PC_W-1:0] seq_w;
    logic [PC_W-1:0] tgt_w;
    logic [PC_W-1:0] nxt_w;
    npc_pick_e       pick_w;

    npc_seq_add #(.PC_W(PC_W), .STEP(STEP)) u_seq (
        .cur_pc (state_q.pc),
        .seq_pc (seq_w)
    );

    npc_tgt_add #(.PC_W(PC_W), .IMM_W(IMM_W), .SHIFT(SHIFT)) u_tgt (
        .seq_pc (seq_w),
        .imm    (imm),
        .tgt_pc (tgt_w)
    );

    npc_pick #(.PC_W(PC_W)) u_pick (
        .br_op  (br_op),
        .src_eq (src_eq),
        .seq_pc (seq_w),
        .tgt_pc (tgt_w),
        .pick   (pick_w),
        .nxt_pc (nxt_w)
    );

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.pc = RST_V;
        end else begin
            state_d.pc = nxt_w;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign pc = state_q.pc;

    logic unused_w;
    assign unused_w = ^pick_w;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int PC_W     = 32,
    parameter int IMM_W    = 16,
    parameter int RESET_PC = 0
) (
    input logic             clk,
    input logic             rst,
    input logic             br_op,
    input logic             src_eq,
    input logic [IMM_W-1:0] imm,
    input logic [PC_W-1:0]  pc
);
    logic            rst_seen_q;
    logic [PC_W-1:0] scaled_w;

    // Reset value of the previous edge, kept so that the PC can be compared after it.
    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
    end

    assign scaled_w = PC_W'($signed(imm)) * PC_W'(4);

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst_seen_q |-> pc == PC_W'(RESET_PC));

    // R2 R5 R7 R9
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(br_op)) |-> pc == $past(pc) + PC_W'(4));

    // R4
    unequal_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(br_op) && !$past(src_eq)) |-> pc == $past(pc) + PC_W'(4));

    // R3 R6
    taken_tgt_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(br_op) && $past(src_eq))
            |-> pc == $past(pc) + PC_W'(4) + $past(scaled_w));

    // R8
    word_align_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> pc[1:0] == 2'b00);
endmodule

bind npc_unit npc_unit_chk #(
    .PC_W     (PC_W),
    .IMM_W    (IMM_W),
    .RESET_PC (RESET_PC)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .br_op  (br_op),
    .src_eq (src_eq),
    .imm    (imm),
    .pc     (pc)
);

// File: tb/npc_unit_test.sv
module npc_unit_test;
    localparam time PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        br_op = 1'b0;
    logic        src_eq = 1'b0;
    logic [15:0] imm = 16'h0;
    logic [31:0] pc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    longint unsigned model_pc = 0;

    npc_unit uut (
        .clk    (clk),
        .rst    (rst),
        .br_op  (br_op),
        .src_eq (src_eq),
        .imm    (imm),
        .pc     (pc)
    );

    always #(PERIOD/2) clk = ~clk;

    // One clock: drive on the falling edge, update the model at the rising edge, compare a quarter period later.
    task automatic cyc(input bit r, input bit b, input bit e, input logic [15:0] i, input string tag);
        longint signed off;
        @(negedge clk);
        rst = r; br_op = b; src_eq = e; imm = i;
        @(posedge clk);
        off = longint'($signed(i)) * 4;
        if (r) model_pc = 0;
        else if (b && e) model_pc = (model_pc + 4 + longint'(off)) % 64'h1_0000_0000;
        else model_pc = (model_pc + 4) % 64'h1_0000_0000;
        #(PERIOD/4);
        checks++;
        if (pc !== model_pc[31:0]) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, pc, model_pc[31:0]);
        end
    endtask

    initial begin
        #(PERIOD*5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(1, 0, 0, 16'h0, "R1 reset");
        cyc(1, 1, 1, 16'h0040, "R1 reset overrides branch");
        for (int k = 0; k < 4; k++) cyc(0, 0, 0, 16'h0, "R2 sequential");
        cyc(0, 0, 0, 16'hABCD, "R9 imm ignored without branch");
        cyc(0, 1, 0, 16'h0100, "R4 unequal no branch");
        cyc(0, 0, 1, 16'h0100, "R5 equal without branch op");
        cyc(0, 1, 1, 16'h0010, "R3 forward branch");
        cyc(0, 1, 1, 16'h0000, "R3 zero offset");
        cyc(0, 1, 1, 16'h7FFF, "R3 largest forward");
        cyc(0, 1, 1, 16'hFFF0, "R6 backward branch");
        cyc(0, 1, 1, 16'h8000, "R6 largest backward");
        cyc(0, 0, 0, 16'h0, "R8 alignment");
        cyc(1, 0, 0, 16'h0, "R1 reset mid run");
        cyc(0, 1, 1, 16'hFFFE, "R6 wrap below zero");
        if (pc !== 32'hFFFF_FFFC) begin
            errors++;
            $display("FAIL R6 actual=%h expected=%h", pc, 32'hFFFF_FFFC);
        end
        checks++;
        cyc(0, 0, 0, 16'h0, "R7 wrap to zero");
        if (pc !== 32'h0) begin
            errors++;
            $display("FAIL R7 actual=%h expected=%h", pc, 32'h0);
        end
        checks++;
        for (int k = 0; k < 40; k++) begin
            cyc(0, k[0], k[1], 16'(k * 97 - 1000), "R3 R4 R5 mixed pattern");
            checks++;
            if (pc[1:0] != 2'b00) begin
                errors++;
                $display("FAIL R8 actual=%b expected=00", pc[1:0]);
            end
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule